// File: doc/BRIEF.md
# Packed Narrowing Saturation Unit

This block takes two 64-bit operands and produces one 64-bit result in which every lane is a half-width copy of a wider element, clamped to the range of the narrower type. The two operands are joined into a 128-bit value. The second operand supplies the upper half and the first operand supplies the lower half. That value is cut into equal elements, and each element is narrowed on its own. The narrowed lanes are then packed side by side. Element 0 of the joined value, which holds its lowest bits, lands in result lane 0.

A two-bit op select chooses one of three modes:
- four 32-bit elements narrowed to signed 16-bit words;
- eight 16-bit elements narrowed to signed bytes;
- eight 16-bit elements treated as unsigned and narrowed to unsigned bytes.

A value that fits in the target type keeps its low bits. A value that does not fit is replaced by the nearest limit of that type. The result is registered one clock after an input strobe. The fourth op encoding is reserved. It yields a zero result and raises a flag alongside the valid strobe.

Top module: `narrow_sat_top`

## Requirements
- R1: After reset, outValid and illegalOp are 0 and result is all zeros.
- R2: outValid is 1 in exactly the cycle after a cycle with inValid high, and 0 otherwise.
- R3: The 128-bit intermediate is {opB, opA}, with opB in bits 127:64. Narrowed element k, taken from intermediate bits starting at k times the element width, occupies result lane k, and lane 0 is result bits at the bottom.
- R4: With opSel = 0, the intermediate splits into four 32-bit signed elements, each giving one 16-bit result word. A value from -32768 to 32767 keeps its low 16 bits.
- R5: With opSel = 0, an element above 32767 gives 16'h7FFF, and an element below -32768 gives 16'h8000.
- R6: With opSel = 1, the intermediate splits into eight 16-bit signed elements, each giving one byte. Values from -128 to 127 keep their low byte, larger values give 8'h7F, and smaller values give 8'h80.
- R7: With opSel = 2, the intermediate splits into eight 16-bit unsigned elements. An element of 255 or less keeps its low byte, and any larger element, including one with its top bit set, gives 8'hFF.
- R8: With opSel = 3, the result is all zeros and illegalOp is 1 in the same cycle as outValid. illegalOp is 0 whenever outValid is 0 or the captured op was 0, 1 or 2.
- R9: In a cycle after inValid was low, result keeps its previous value whatever opA, opB and opSel carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands and op select are valid this cycle |
| opSel | input | 2 | 0 signed 32 to 16, 1 signed 16 to 8, 2 unsigned 16 to 8, 3 reserved |
| opA | input | 64 | First operand, lower half of the intermediate |
| opB | input | 64 | Second operand, upper half of the intermediate |
| outValid | output | 1 | Result register loaded in the previous cycle |
| result | output | 64 | Packed narrowed lanes |
| illegalOp | output | 1 | Reserved op captured; result is zero |

## Verification
The design has a single register stage, so a fault in its state shows up at the ports on the very next sampling edge.
- A lost or repeated load strobe gives an outValid that no longer trails inValid by one cycle. It also lets result change during idle cycles.
- A lane decode that picks the wrong element, or swaps the operand halves, moves a known clamped pattern into a neighbouring lane.
- A mis-set signed/unsigned control turns the 7F/80 clamps into FF, or turns FF into 7F/80, on the first boundary vector sent.

// File: rtl/narrow_sat_pkg.sv
package narrow_sat_pkg;

  typedef enum logic [1:0] {
    OP_S32TO16 = 2'd0,
    OP_S16TO8  = 2'd1,
    OP_U16TO8  = 2'd2,
    OP_RSVD    = 2'd3
  } narrowOpE;

  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic wideElem;   // 32-bit elements when set, 16-bit otherwise
    logic signedSat;  // signed clamp when set, unsigned otherwise
    logic zeroOut;    // reserved op: force the result to zero
  } dpCtrlT;

endpackage

// File: rtl/narrow_ctrl.sv
module narrow_ctrl
  import narrow_sat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  output dpCtrlT     ctrl,
  output logic       outValid,
  output logic       illegalOp
);

  narrowOpE opDec;
  assign opDec = narrowOpE'(opSel);

  always_comb begin
    ctrl           = '0;
    ctrl.load      = inValid;
    ctrl.wideElem  = 1'b0;
    ctrl.signedSat = 1'b0;
    ctrl.zeroOut   = 1'b0;
    case (opDec)
      OP_S32TO16: begin
        ctrl.wideElem  = 1'b1;
        ctrl.signedSat = 1'b1;
      end
      OP_S16TO8: ctrl.signedSat = 1'b1;
      OP_U16TO8: ctrl.signedSat = 1'b0;
      default:   ctrl.zeroOut   = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid && (opDec == OP_RSVD);
    end
  end

endmodule

// File: rtl/narrow_dp.sv
module narrow_dp
  import narrow_sat_pkg::*;
#(
  parameter int OPW    = 64,
  parameter int WORD_W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtrlT         ctrl,
  input  logic [OPW-1:0] opA,
  input  logic [OPW-1:0] opB,
  output logic [OPW-1:0] result
);

  localparam int CAT_W  = 2 * OPW;
  localparam int DW_W   = 2 * WORD_W;
  localparam int BYTE_W = WORD_W / 2;
  localparam int N_DW   = CAT_W / DW_W;
  localparam int N_WD   = CAT_W / WORD_W;
  localparam int DW_EXT = DW_W - WORD_W + 1;
  localparam int WD_EXT = WORD_W - BYTE_W + 1;

  logic [CAT_W-1:0] catVal;
  logic [OPW-1:0]   dwPacked;
  logic [OPW-1:0]   wdPacked;
  logic [OPW-1:0]   nextResult;

  assign catVal = {opB, opA};

  // 32-bit signed elements to 16-bit signed lanes
  for (genvar i = 0; i < N_DW; i++) begin : g_dwLane
    logic [DW_W-1:0]   elem;
    logic              fits;
    logic [WORD_W-1:0] lane;
    assign elem = catVal[i*DW_W +: DW_W];
    assign fits = (elem[DW_W-1:WORD_W-1] == {DW_EXT{elem[DW_W-1]}});
    always_comb begin
      if (fits)               lane = elem[WORD_W-1:0];
      else if (elem[DW_W-1])  lane = {1'b1, {(WORD_W-1){1'b0}}};
      else                    lane = {1'b0, {(WORD_W-1){1'b1}}};
    end
    assign dwPacked[i*WORD_W +: WORD_W] = lane;
  end

  // 16-bit elements to 8-bit lanes, signed or unsigned clamp
  for (genvar j = 0; j < N_WD; j++) begin : g_wdLane
    logic [WORD_W-1:0] elem;
    logic              sFits;
    logic              uFits;
    logic [BYTE_W-1:0] lane;
    assign elem  = catVal[j*WORD_W +: WORD_W];
    assign sFits = (elem[WORD_W-1:BYTE_W-1] == {WD_EXT{elem[WORD_W-1]}});
    assign uFits = (elem[WORD_W-1:BYTE_W] == '0);
    always_comb begin
      if (ctrl.signedSat) begin
        if (sFits)               lane = elem[BYTE_W-1:0];
        else if (elem[WORD_W-1]) lane = {1'b1, {(BYTE_W-1){1'b0}}};
        else                     lane = {1'b0, {(BYTE_W-1){1'b1}}};
      end else begin
        lane = uFits ? elem[BYTE_W-1:0] : {BYTE_W{1'b1}};
      end
    end
    assign wdPacked[j*BYTE_W +: BYTE_W] = lane;
  end

  always_comb begin
    if (ctrl.zeroOut)       nextResult = '0;
    else if (ctrl.wideElem) nextResult = dwPacked;
    else                    nextResult = wdPacked;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= nextResult;
  end

endmodule

// File: rtl/narrow_sat_top.sv
module narrow_sat_top
  import narrow_sat_pkg::*;
#(
  parameter int OPW    = 64,
  parameter int WORD_W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [1:0]     opSel,
  input  logic [OPW-1:0] opA,
  input  logic [OPW-1:0] opB,
  output logic           outValid,
  output logic [OPW-1:0] result,
  output logic           illegalOp
);

  dpCtrlT ctrl;

  narrow_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .opSel     (opSel),
    .ctrl      (ctrl),
    .outValid  (outValid),
    .illegalOp (illegalOp)
  );

  narrow_dp #(.OPW(OPW), .WORD_W(WORD_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/narrow_chk.sv
module narrow_chk #(
  parameter int OPW = 64
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic [1:0]     opSel,
  input logic [OPW-1:0] opA,
  input logic           outValid,
  input logic [OPW-1:0] result,
  input logic           illegalOp
);

  // R2
  in_to_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  out_from_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (outValid && result == '0));

  // R8
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 2'd3) |-> illegalOp);

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

  // R7
  unsigned_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 2'd2 && $past(opA[15:8]) != 8'h00)
      |-> result[7:0] == 8'hFF);

endmodule

bind narrow_sat_top narrow_chk #(.OPW(OPW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opSel     (opSel),
  .opA       (opA),
  .outValid  (outValid),
  .result    (result),
  .illegalOp (illegalOp)
);

// File: tb/tb_narrow_sat_top.sv
`timescale 1ns/1ps
module tb_narrow_sat_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegalOp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  narrow_sat_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .illegalOp(illegalOp)
  );

  function automatic logic [63:0] model(input logic [1:0] op,
                                        input logic [63:0] a,
                                        input logic [63:0] b);
    logic [127:0] c;
    logic [63:0]  r;
    int           v;
    int unsigned  u;
    c = {b, a};
    r = '0;
    case (op)
      2'd0: for (int k = 0; k < 4; k++) begin
        v = $signed(c[k*32 +: 32]);
        if (v > 32767)       r[k*16 +: 16] = 16'h7FFF;
        else if (v < -32768) r[k*16 +: 16] = 16'h8000;
        else                 r[k*16 +: 16] = v[15:0];
      end
      2'd1: for (int k = 0; k < 8; k++) begin
        v = int'($signed(c[k*16 +: 16]));
        if (v > 127)       r[k*8 +: 8] = 8'h7F;
        else if (v < -128) r[k*8 +: 8] = 8'h80;
        else               r[k*8 +: 8] = v[7:0];
      end
      2'd2: for (int k = 0; k < 8; k++) begin
        u = {16'h0, c[k*16 +: 16]};
        r[k*8 +: 8] = (u > 255) ? 8'hFF : u[7:0];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runOne(input string req, input logic [1:0] op,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    check(req, "outValid", {63'd0, outValid}, 64'd1);
    check(req, "result", result, model(op, a, b));
    check(req, "illegalOp", {63'd0, illegalOp}, {63'd0, op == 2'd3});
  endtask

  task automatic testReset();
    check("R1", "outValid after reset", {63'd0, outValid}, 64'd0);
    check("R1", "illegalOp after reset", {63'd0, illegalOp}, 64'd0);
    check("R1", "result after reset", result, 64'd0);
  endtask

  task automatic testDword();
    // R4 in-range values, R5 clamps; R3 ordering via distinct lanes
    runOne("R4", 2'd0, 64'h0000_1234_FFFF_8000, 64'h0000_7FFF_FFFF_FFFE);
    check("R3", "explicit lane order", result, 64'h7FFF_FFFE_1234_8000);
    runOne("R5", 2'd0, 64'h0000_8000_FFFF_7FFF, 64'h8000_0000_7FFF_FFFF);
    check("R5", "explicit clamps", result, 64'h8000_7FFF_7FFF_8000);
  endtask

  task automatic testSignedByte();
    runOne("R6", 2'd1, 64'h0080_FF7F_007F_FF80, 64'h8000_7FFF_0001_FFFF);
    check("R6", "explicit bytes", result, 64'h807F_01FF_7F80_7F80);
    // R3: upper half from opB only
    runOne("R3", 2'd1, 64'h0, 64'h0011_0022_0033_0044);
    check("R3", "opB in upper lanes", result, 64'h1122_3344_0000_0000);
  endtask

  task automatic testUnsignedByte();
    runOne("R7", 2'd2, 64'h00FF_0100_8000_0042, 64'hFFFF_0000_00FE_0200);
    check("R7", "explicit bytes", result, 64'hFF00_FEFF_FFFF_FF42);
  endtask

  task automatic testIllegal();
    runOne("R8", 2'd3, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    check("R8", "illegalOp drops with outValid", {63'd0, illegalOp}, 64'd0);
  endtask

  task automatic testHold();
    logic [63:0] held;
    runOne("R9", 2'd2, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008);
    held = result;
    for (int n = 0; n < 3; n++) begin
      opA = 64'hDEAD_BEEF_0000_FFFF; opB = ~opA; opSel = 2'(n);
      @(negedge clk);
      check("R9", "result holds while idle", result, held);
      check("R2", "outValid low while idle", {63'd0, outValid}, 64'd0);
    end
  endtask

  task automatic testBackToBack();
    logic [1:0]  ops [4];
    logic [63:0] as [4];
    logic [63:0] bs [4];
    for (int n = 0; n < 4; n++) begin
      ops[n] = 2'(n);
      as[n] = {$urandom, $urandom};
      bs[n] = {$urandom, $urandom};
    end
    @(negedge clk);
    for (int n = 0; n < 4; n++) begin
      inValid = 1'b1; opSel = ops[n]; opA = as[n]; opB = bs[n];
      @(negedge clk);
      check("R2", "back-to-back outValid", {63'd0, outValid}, 64'd1);
      check("R2", "back-to-back result", result, model(ops[n], as[n], bs[n]));
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R2", "outValid drops after burst", {63'd0, outValid}, 64'd0);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 40; n++) begin
      runOne(n % 3 == 0 ? "R4" : (n % 3 == 1 ? "R6" : "R7"),
             2'(n % 3), {$urandom, $urandom}, {$urandom, $urandom});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDword();
    testSignedByte();
    testUnsignedByte();
    testIllegal();
    testHold();
    testBackToBack();
    testRandom();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule